// File: doc/BRIEF.md
# Byte-Masked GPIO Port with Open-Drain / Open-Source Drive

This block is a general-purpose I/O port of 24 pins, split into three banks of eight. A host reaches it through a small byte-wide register port: one write strobe, an address, write data, and read data that follows the address in the same cycle. For every pin the block produces an output level and an output enable. The pad cell outside the block turns these into a push-pull driver, a pull-to-ground-only driver or a pull-to-supply-only driver.

Output data is never written as a whole byte. The host first writes a value byte, which is held in a staging register. It then writes a mask byte to the bank's mask address, and only the bits whose mask bit is set take the staged value. Software can therefore toggle single pins with no read-modify-write and no race against other pins. Each pin also has a direction bit, and a pair of single-ended bits: a mode bit and an enable bit. Pad levels pass through a two-stage synchronizer and can be read back at the bank's data address.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin's output enable is 0, and every direction, open-drain mode and open-drain enable register reads 0. The output data latch is 0, so a pin later turned to push-pull output drives 0 until a masked write changes it.
- R2: A write to a bank's value address changes no output. It only records the byte in one staging register shared by all banks, where the last value write wins. A write to bank b's mask address sets each data bit whose mask bit is 1 to the staged bit.
- R3: Data bits whose mask bit is 0 keep their previous value, so a mask of 0x00 changes nothing.
- R4: The value byte of bank b is at address 2b and its mask byte at 2b+1. Pin p belongs to bank p/8, bit p%8, and appears on padOut[p] and padOe[p].
- R5: The direction register of bank b is at address 8+b. A bit of 1 makes the pin an output, and a bit of 0 makes it an input with padOe=0. An output in push-pull drives padOe=1 and padOut=data. padOut is only meaningful where padOe is 1.
- R6: With open-drain enable 1 and mode 0, an output pin drives low only: padOut=0 and padOe is the inverse of the data bit.
- R7: With open-drain enable 1 and mode 1, an output pin drives high only: padOut=1 and padOe equals the data bit.
- R8: With open-drain enable 0 the pin is push-pull whatever its mode bit is.
- R9: The mode register of bank b is at address 16+2b and the enable register at 17+2b. Direction, mode and enable registers read back the value last written.
- R10: Reading a bank's value address returns that bank's pad levels after a two-flop synchronizer, whatever the pin directions. A pad change set up before clock edge k is visible after edge k+1 and not after edge k.
- R11: Writes to any other address, mask addresses included for reads, have no effect on state. Reads of unmapped addresses and of mask addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| regWe | input | 1 | Register write strobe for one cycle |
| regAddr | input | 8 | Byte address for write and read |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, combinational |
| padIn | input | 24 | Pad input levels, asynchronous |
| padOut | output | 24 | Per-pin output level |
| padOe | output | 24 | Per-pin output enable |

## Verification
Most internal faults show at the pads within one clock of the write that exposes them. A staging register that commits early shows as a pin change on the value write itself. A wrong mask polarity, or a mask write decoded to the wrong bank, moves pins that should hold, and this is visible on padOut and padOe at the next edge. A mode and enable pair that is swapped or misdecoded shows as wrong enables on pins whose data bit differs from the mode. A synchronizer that is too short or too long shows as a read value that changes one edge early or one edge late.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  localparam int BANK_SEL_W = 8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PADIN,
    RD_DIR,
    RD_ODMODE,
    RD_ODEN
  } rdSel_e;

  // Strobes from address decode to the register datapath
  typedef struct packed {
    logic                  valueWr;
    logic                  maskWr;
    logic                  dirWr;
    logic                  odmWr;
    logic                  odeWr;
    rdSel_e                rdSel;
    logic [BANK_SEL_W-1:0] bank;
  } strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 3,
  parameter int DATA_BASE = 0,
  parameter int DIR_BASE  = 8,
  parameter int OD_BASE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);

  localparam logic [ADDR_W:0] DATA_LO = (ADDR_W+1)'(DATA_BASE);
  localparam logic [ADDR_W:0] DATA_HI = (ADDR_W+1)'(DATA_BASE + 2*NUM_BANKS);
  localparam logic [ADDR_W:0] DIR_LO  = (ADDR_W+1)'(DIR_BASE);
  localparam logic [ADDR_W:0] DIR_HI  = (ADDR_W+1)'(DIR_BASE + NUM_BANKS);
  localparam logic [ADDR_W:0] OD_LO   = (ADDR_W+1)'(OD_BASE);
  localparam logic [ADDR_W:0] OD_HI   = (ADDR_W+1)'(OD_BASE + 2*NUM_BANKS);

  logic [ADDR_W:0] addrExt;
  logic [ADDR_W:0] offset;

  assign addrExt = {1'b0, regAddr};

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    offset    = '0;
    if (addrExt >= DATA_LO && addrExt < DATA_HI) begin
      offset   = addrExt - DATA_LO;
      stb.bank = BANK_SEL_W'(offset >> 1);
      if (offset[0]) begin
        stb.maskWr = regWe;
      end else begin
        stb.valueWr = regWe;
        stb.rdSel   = RD_PADIN;
      end
    end else if (addrExt >= DIR_LO && addrExt < DIR_HI) begin
      offset    = addrExt - DIR_LO;
      stb.bank  = BANK_SEL_W'(offset);
      stb.dirWr = regWe;
      stb.rdSel = RD_DIR;
    end else if (addrExt >= OD_LO && addrExt < OD_HI) begin
      offset   = addrExt - OD_LO;
      stb.bank = BANK_SEL_W'(offset >> 1);
      if (offset[0]) begin
        stb.odeWr = regWe;
        stb.rdSel = RD_ODEN;
      end else begin
        stb.odmWr = regWe;
        stb.rdSel = RD_ODMODE;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.valueWr, stb.maskWr, stb.dirWr, stb.odmWr, stb.odeWr})); // R4

  AST_NO_WE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !regWe |-> !(stb.valueWr || stb.maskWr || stb.dirWr || stb.odmWr || stb.odeWr)); // R11

endmodule

// File: rtl/gpio_port_datapath.sv
`timescale 1ns/1ps
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobe_t                     stb,
  input  logic [BANK_W-1:0]           wdata,
  input  logic [NUM_BANKS*BANK_W-1:0] padIn,
  output logic [NUM_BANKS*BANK_W-1:0] padOut,
  output logic [NUM_BANKS*BANK_W-1:0] padOe,
  output logic [BANK_W-1:0]           rdata
);

  localparam int NUM_PINS = NUM_BANKS * BANK_W;

  logic [BANK_W-1:0]   stagedQ;
  logic [BANK_W-1:0]   dataQ [NUM_BANKS];
  logic [BANK_W-1:0]   dirQ  [NUM_BANKS];
  logic [BANK_W-1:0]   odmQ  [NUM_BANKS];
  logic [BANK_W-1:0]   odeQ  [NUM_BANKS];
  logic [NUM_PINS-1:0] sync1Q;
  logic [NUM_PINS-1:0] sync2Q;

  // Register state
  always_ff @(posedge clk) begin
    if (rst) begin
      stagedQ <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        dataQ[b] <= '0;
        dirQ[b]  <= '0;
        odmQ[b]  <= '0;
        odeQ[b]  <= '0;
      end
    end else begin
      if (stb.valueWr) stagedQ <= wdata;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (stb.bank == BANK_SEL_W'(b)) begin
          if (stb.maskWr) dataQ[b] <= (dataQ[b] & ~wdata) | (stagedQ & wdata);
          if (stb.dirWr)  dirQ[b]  <= wdata;
          if (stb.odmWr)  odmQ[b]  <= wdata;
          if (stb.odeWr)  odeQ[b]  <= wdata;
        end
      end
    end
  end

  // Two-flop pad synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1Q <= '0;
      sync2Q <= '0;
    end else begin
      sync1Q <= padIn;
      sync2Q <= sync1Q;
    end
  end

  // Per-pin drive selection
  always_comb begin
    padOut = '0;
    padOe  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < BANK_W; i++) begin
        if (!odeQ[b][i]) begin
          padOut[b*BANK_W+i] = dataQ[b][i];
          padOe[b*BANK_W+i]  = dirQ[b][i];
        end else if (odmQ[b][i]) begin
          padOut[b*BANK_W+i] = 1'b1;
          padOe[b*BANK_W+i]  = dirQ[b][i] & dataQ[b][i];
        end else begin
          padOut[b*BANK_W+i] = 1'b0;
          padOe[b*BANK_W+i]  = dirQ[b][i] & ~dataQ[b][i];
        end
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stb.bank == BANK_SEL_W'(b)) begin
        unique case (stb.rdSel)
          RD_PADIN:  rdata = sync2Q[b*BANK_W +: BANK_W];
          RD_DIR:    rdata = dirQ[b];
          RD_ODMODE: rdata = odmQ[b];
          RD_ODEN:   rdata = odeQ[b];
          default:   rdata = '0;
        endcase
      end
    end
  end

  // Checks
  logic [1:0] settleQ;
  always_ff @(posedge clk) begin
    if (rst)                settleQ <= '0;
    else if (settleQ != 2'd2) settleQ <= settleQ + 2'd1;
  end

  AST_SYNC_TWO_STAGES: assert property (@(posedge clk) disable iff (rst)
    (settleQ == 2'd2) |-> (sync2Q == $past(padIn, 2))); // R10

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : gBankChk
    AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
      (stb.maskWr && stb.bank == BANK_SEL_W'(gb))
      |=> (((dataQ[gb] ^ $past(dataQ[gb])) & ~$past(wdata)) == '0)); // R3

    AST_DATA_ONLY_ON_MASK: assert property (@(posedge clk) disable iff (rst)
      !(stb.maskWr && stb.bank == BANK_SEL_W'(gb)) |=> $stable(dataQ[gb])); // R2
  end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_BASE = 0,
  parameter int DIR_BASE  = 8,
  parameter int OD_BASE   = 16,
  localparam int NUM_PINS = NUM_BANKS * BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BANK_W-1:0]   regWdata,
  output logic [BANK_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);

  strobe_t stb;

  gpio_port_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
    .DATA_BASE(DATA_BASE), .DIR_BASE(DIR_BASE), .OD_BASE(OD_BASE)
  ) uCtrl (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .stb(stb)
  );

  gpio_port_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
  ) uData (
    .clk(clk), .rst(rst), .stb(stb), .wdata(regWdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .rdata(regRdata)
  );

endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic [23:0] padIn = '0;
  logic [23:0] padOut;
  logic [23:0] padOe;

  always #5 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Bench model
  logic [7:0]  mData [3];
  logic [7:0]  mDir  [3];
  logic [7:0]  mOdm  [3];
  logic [7:0]  mOde  [3];
  logic [7:0]  mStaged;
  logic [23:0] mPad;

  function automatic logic [23:0] expOe();
    logic [23:0] r = '0;
    for (int p = 0; p < 24; p++) begin
      int b = p / 8;
      int i = p % 8;
      if (!mDir[b][i])      r[p] = 1'b0;
      else if (!mOde[b][i]) r[p] = 1'b1;
      else if (mOdm[b][i])  r[p] = mData[b][i];
      else                  r[p] = ~mData[b][i];
    end
    return r;
  endfunction

  function automatic logic [23:0] expOut();
    logic [23:0] r = '0;
    for (int p = 0; p < 24; p++) begin
      int b = p / 8;
      int i = p % 8;
      if (!mOde[b][i]) r[p] = mData[b][i];
      else             r[p] = mOdm[b][i];
    end
    return r;
  endfunction

  function automatic logic [7:0] expRd(input logic [7:0] a);
    if (a == 8'd0 || a == 8'd2 || a == 8'd4) return mPad[8*(a/2) +: 8];
    if (a >= 8'd8 && a <= 8'd10) return mDir[a-8];
    if (a >= 8'd16 && a <= 8'd21) return a[0] ? mOde[(a-16)/2] : mOdm[(a-16)/2];
    return 8'h00;
  endfunction

  function automatic void applyWr(input logic [7:0] a, input logic [7:0] d);
    if (a <= 8'd5) begin
      if (!a[0]) mStaged = d;
      else mData[a/2] = (mData[a/2] & ~d) | (mStaged & d);
    end else if (a >= 8'd8 && a <= 8'd10) begin
      mDir[a-8] = d;
    end else if (a >= 8'd16 && a <= 8'd21) begin
      if (a[0]) mOde[(a-16)/2] = d;
      else      mOdm[(a-16)/2] = d;
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 regWe = 1'b0;
    applyWr(a, d);
  endtask

  task automatic chkPads(input string req);
    logic [23:0] eo;
    @(negedge clk);
    eo = expOe();
    chk(req, padOe, eo);
    chk(req, padOut & eo, expOut() & eo);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    @(negedge clk);
    regAddr = a;
    #1 chk(req, regRdata, expRd(a));
  endtask

  task automatic setPad(input logic [23:0] v);
    @(negedge clk);
    padIn = v;
    mPad = v;
    repeat (2) @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [7:0] mapped [15] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd8, 8'd9,
                                8'd10, 8'd16, 8'd17, 8'd18, 8'd19, 8'd20, 8'd21};
    void'($urandom(32'd20240611));
    for (int b = 0; b < 3; b++) begin
      mData[b] = '0; mDir[b] = '0; mOdm[b] = '0; mOde[b] = '0;
    end
    mStaged = '0; mPad = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk("R1 oe after reset", padOe, 24'h0);
    rd(8'd8, "R1 dir bank0"); rd(8'd10, "R1 dir bank2");
    rd(8'd17, "R1 od enable bank0"); rd(8'd20, "R1 od mode bank2");
    wr(8'd8, 8'hFF);
    chkPads("R1 data zero on first output");

    // R2 value write alone, then commit with mask; R4 address
    wr(8'd9, 8'hFF);
    wr(8'd2, 8'hFF);
    chkPads("R2 value write changes nothing");
    wr(8'd3, 8'h0F);
    chkPads("R2 mask commit bank1");
    chk("R4 bank1 low nibble", padOut[15:8], 8'h0F);
    // R3 zero mask
    wr(8'd2, 8'h00);
    wr(8'd3, 8'h00);
    chkPads("R3 zero mask holds");
    chk("R3 bank1 kept", padOut[15:8], 8'h0F);
    wr(8'd3, 8'h30);
    chk("R3 partial mask", padOut[15:8], 8'h0F);
    // R4 pin 17 = bank2 bit1
    wr(8'd4, 8'h02); wr(8'd5, 8'h02); wr(8'd10, 8'h02);
    chkPads("R4 pin17");
    chk("R4 pin17 driven", {31'd0, padOe[17] & padOut[17]}, 32'd1);

    // R5 direction in/out, R6 open-drain, R7 open-source, R8 push-pull override
    wr(8'd0, 8'hAA); wr(8'd1, 8'hFF);
    wr(8'd8, 8'h0F);
    chkPads("R5 mixed direction");
    wr(8'd8, 8'hFF);
    wr(8'd17, 8'hFF); wr(8'd16, 8'h00);
    chkPads("R6 open drain");
    chk("R6 oe inverse", padOe[7:0], 8'h55);
    wr(8'd16, 8'hFF);
    chkPads("R7 open source");
    chk("R7 oe follows data", padOe[7:0], 8'hAA);
    chk("R7 out high", padOut[7:0], 8'hFF);
    wr(8'd17, 8'h00);
    chkPads("R8 enable off push-pull");
    chk("R8 oe all", padOe[7:0], 8'hFF);

    // R9 readback
    wr(8'd19, 8'h5C); wr(8'd18, 8'hC3); wr(8'd9, 8'h81);
    rd(8'd19, "R9 enable bank1"); rd(8'd18, "R9 mode bank1"); rd(8'd9, "R9 dir bank1");

    // R10 synchronizer latency
    @(negedge clk);
    padIn = 24'hA5C33C;
    @(posedge clk);
    @(negedge clk);
    regAddr = 8'd2;
    #1 chk("R10 not yet after one edge", regRdata, 8'h00);
    @(posedge clk);
    mPad = 24'hA5C33C;
    rd(8'd2, "R10 visible after two edges");
    rd(8'd4, "R10 bank2"); rd(8'd0, "R10 bank0 input pins");

    // R11 unmapped writes and reads
    wr(8'd6, 8'hFF); wr(8'd11, 8'hFF); wr(8'd22, 8'hFF); wr(8'd255, 8'hFF);
    chkPads("R11 unmapped writes");
    rd(8'd1, "R11 mask reads zero"); rd(8'd7, "R11 unmapped read");
    rd(8'd8, "R11 dir unchanged"); rd(8'd21, "R11 enable unchanged");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) begin
        wr(mapped[$urandom_range(0, 14)], 8'($urandom));
        chkPads("R2/R5/R6/R7 random write");
      end else if (op < 7) begin
        wr(8'($urandom_range(22, 255)), 8'($urandom));
        chkPads("R11 random unmapped");
      end else if (op < 8) begin
        setPad(24'($urandom));
        rd(8'(2 * $urandom_range(0, 2)), "R10 random pad");
      end else begin
        rd(8'($urandom_range(0, 31)), "R9/R11 random read");
      end
    end

    finished = 1'b1;
    summary();
  end

endmodule